// File: doc/BRIEF.md
# Data Watchpoint Address Matcher

The block holds a small set of data watchpoints and compares every load or store address presented on its access port against them. Each watchpoint has a base-address register and a control register. The control register enables breaking on loads, on stores or on both, and carries a 6-bit field that selects how many low-order address bits take part in the compare. A match raises a break request in the same cycle as the access, so the pipeline can stop the access before it takes effect. The output also gives the index of the watchpoint that fired.

The mask field must describe a naturally aligned, power-of-two region, so its ones must sit above its zeros. When a control write carries a field that breaks this rule, the block trims the field when the value is stored. Ones are kept from the top of the field down to the first zero, and every bit from that zero downward is cleared. A sticky flag records that a trim took place. Delivering the debug exception is left to the pipeline.

Top module: `dbw_matcher`

## Requirements
- R1: After reset every watchpoint is disabled, `brk_hit` and `brk_idx` are 0 and `mask_fixed` is 0; no access hits until a watchpoint is programmed.
- R2: Control word layout: bit 31 enables breaking on stores, bit 30 enables breaking on loads, and bits 5:0 hold the mask field. All other control bits have no effect.
- R3: A watchpoint with only the store enable hits only on stores (`acc_store`=1). One with only the load enable hits only on loads (`acc_store`=0). One with neither enable never hits.
- R4: The compare mask M is all ones above bit 5, with the stored mask field in bits 5:0. An access hits when (acc_addr & M) == (base & M). With a contiguous field, the watched region starts at base & M and is ~M+1 bytes long: the first and last bytes hit and the byte one past the end does not.
- R5: A non-contiguous field (for example 101100) is stored trimmed: field bits stay set from bit 5 down to the first zero, and that bit and all lower bits are cleared (101100 becomes 100000, a 32-byte region).
- R6: `mask_fixed` becomes 1 in the cycle after a control write that has at least one enable set and a non-contiguous field. It stays 1 until `mask_fixed_clr` is pulsed; if a set and a clear happen in the same cycle, the set wins. A non-contiguous write with both enables clear does not set it.
- R7: `brk_hit` is combinational on the access port: it is valid in the same cycle as `acc_valid` and is 0 whenever `acc_valid` is 0.
- R8: When several watchpoints hit at once, `brk_idx` gives the lowest index; `brk_idx` is 0 when there is no hit.
- R9: A write to an address or control register takes effect for accesses from the cycle after the write edge onward, with no extra arming step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ctrl | input | 1 | 1 selects the control register, 0 the address register |
| cfg_idx | input | 1 | Watchpoint index of the write (IDX_W bits) |
| cfg_wdata | input | 32 | Write data |
| mask_fixed_clr | input | 1 | Clears the sticky trim flag |
| acc_valid | input | 1 | Memory access present this cycle |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | 32 | Access address |
| brk_hit | output | 1 | Break request for the current access |
| brk_idx | output | 1 | Index of the winning watchpoint (IDX_W bits) |
| mask_fixed | output | 1 | Sticky flag: a mask field was trimmed |

## Verification
A stored mask that is wrong makes a region boundary move. The effect shows at once on the first, last or one-past-the-end access of a region, so the bench probes all three for both a contiguous and a trimmed field, including an address that only the trimmed mask matches. Enable bits that are wrong show as a hit on the wrong access direction in the cycle after the write. A priority fault shows on `brk_idx` as soon as two watchpoints overlap. The sticky flag is read right after each control write and right after each clear.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
   // Mask field width within the control word
   localparam int unsigned FIELD_W = 6;

   // Trim a mask field so its ones run from the MSB down to the first zero
   function automatic logic [FIELD_W-1:0] trim_field(input logic [FIELD_W-1:0] f);
      logic [FIELD_W-1:0] r;
      logic               run;
      run = 1'b1;
      for (int i = FIELD_W - 1; i >= 0; i--) begin
         run  = run & f[i];
         r[i] = run;
      end
      return r;
   endfunction
endpackage

// File: rtl/dbw_mask_fix.sv
module dbw_mask_fix
   import dbw_pkg::*;
(
   input  logic [FIELD_W-1:0] field_in,
   output logic [FIELD_W-1:0] field_out,
   output logic               trimmed
);
   logic [FIELD_W-1:0] inv;

   always_comb begin
      field_out = trim_field(field_in);
      trimmed   = (field_out != field_in);
      inv       = ~field_out;
      // R5
      trim_contig_chk: assert (((inv + 1'b1) & inv) == '0);
   end
endmodule

// File: rtl/dbw_slot.sv
module dbw_slot
   import dbw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic              ctrl_we,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_store,
   output logic              match,
   output logic              trim_event
);
   localparam int unsigned ST_BIT = ADDR_W - 1;
   localparam int unsigned LD_BIT = ADDR_W - 2;

   logic [ADDR_W-1:0]  base_q;
   logic [FIELD_W-1:0] field_q;
   logic               st_en_q, ld_en_q;
   logic [FIELD_W-1:0] field_trim;
   logic               field_bad;
   logic [ADDR_W-1:0]  cmp_mask;
   logic               dir_ok;

   dbw_mask_fix i_fix (
      .field_in  (wr_data[FIELD_W-1:0]),
      .field_out (field_trim),
      .trimmed   (field_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         field_q <= '0;
         st_en_q <= 1'b0;
         ld_en_q <= 1'b0;
      end else begin
         if (addr_we) base_q <= wr_data;
         if (ctrl_we) begin
            field_q <= field_trim;
            st_en_q <= wr_data[ST_BIT];
            ld_en_q <= wr_data[LD_BIT];
         end
      end
   end

   assign trim_event = ctrl_we & field_bad & (wr_data[ST_BIT] | wr_data[LD_BIT]);
   assign cmp_mask   = {{(ADDR_W-FIELD_W){1'b1}}, field_q};
   assign dir_ok     = acc_store ? st_en_q : ld_en_q;
   assign match      = dir_ok & (((acc_addr ^ base_q) & cmp_mask) == '0);

   // R3
   disabled_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_en_q | ld_en_q) |-> !match);
   // R9
   rearm_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> (st_en_q == $past(wr_data[ST_BIT])) && (ld_en_q == $past(wr_data[LD_BIT])));
   // R9
   rearm_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_we |=> (base_q == $past(wr_data)));
endmodule

// File: rtl/dbw_prio.sv
module dbw_prio #(
   parameter int unsigned N     = 2,
   parameter int unsigned IDX_W = 1
)(
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
      any = |req;
   end
endmodule

// File: rtl/dbw_matcher.sv
module dbw_matcher #(
   parameter int unsigned NUM_WP = 2,
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned IDX_W = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_ctrl,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              mask_fixed_clr,
   input  logic              acc_valid,
   input  logic              acc_store,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              brk_hit,
   output logic [IDX_W-1:0]  brk_idx,
   output logic              mask_fixed
);
   generate
      if (NUM_WP < 1) begin : g_bad_n
         $error("NUM_WP must be at least 1");
      end
      if (ADDR_W < dbw_pkg::FIELD_W + 2) begin : g_bad_w
         $error("ADDR_W too small for enables and mask field");
      end
   endgenerate

   logic [NUM_WP-1:0] slot_match;
   logic [NUM_WP-1:0] slot_trim;
   logic [NUM_WP-1:0] gated;
   logic              any_hit;
   logic [IDX_W-1:0]  win_idx;
   logic              trim_any;

   for (genvar g = 0; g < NUM_WP; g++) begin : g_slot
      logic sel;
      assign sel = cfg_we & (cfg_idx == IDX_W'(g));
      dbw_slot #(.ADDR_W(ADDR_W)) i_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .addr_we    (sel & ~cfg_ctrl),
         .ctrl_we    (sel & cfg_ctrl),
         .wr_data    (cfg_wdata),
         .acc_addr   (acc_addr),
         .acc_store  (acc_store),
         .match      (slot_match[g]),
         .trim_event (slot_trim[g])
      );
   end

   assign gated = acc_valid ? slot_match : '0;

   dbw_prio #(.N(NUM_WP), .IDX_W(IDX_W)) i_prio (
      .req (gated),
      .any (any_hit),
      .idx (win_idx)
   );

   assign brk_hit  = any_hit;
   assign brk_idx  = win_idx;
   assign trim_any = |slot_trim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               mask_fixed <= 1'b0;
      else if (trim_any)        mask_fixed <= 1'b1;
      else if (mask_fixed_clr)  mask_fixed <= 1'b0;
   end

   // R7
   hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit |-> acc_valid);
   // R8
   winner_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit |-> slot_match[brk_idx]);
   // R8
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit |-> ((slot_match & ((NUM_WP'(1) << brk_idx) - NUM_WP'(1))) == '0));
   // R8
   idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_hit |-> (brk_idx == '0));
   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trim_any |=> mask_fixed);
   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_fixed && !mask_fixed_clr |=> mask_fixed);
   // R6
   flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_fixed && !trim_any |=> !mask_fixed);
endmodule

// File: tb/test_dbw_matcher.sv
module test_dbw_matcher;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_ctrl = 1'b0;
   logic [0:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic        mask_fixed_clr = 1'b0;
   logic        acc_valid = 1'b0, acc_store = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        brk_hit;
   logic [0:0]  brk_idx;
   logic        mask_fixed;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [31:0] ST = 32'h8000_0000;
   localparam logic [31:0] LD = 32'h4000_0000;

   always #10 clk = ~clk;

   dbw_matcher i_dbw_matcher (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .mask_fixed_clr(mask_fixed_clr),
      .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
      .brk_hit(brk_hit), .brk_idx(brk_idx), .mask_fixed(mask_fixed)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input bit idx, input bit ctrl, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ctrl = ctrl; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clr_flag();
      @(negedge clk);
      mask_fixed_clr = 1'b1;
      @(negedge clk);
      mask_fixed_clr = 1'b0;
   endtask

   // Present an access and check hit and index in the same cycle
   task automatic probe(input string req, input logic [31:0] a, input bit st,
                        input bit exp_hit, input bit exp_idx, input bit valid = 1'b1);
      @(negedge clk);
      acc_valid = valid; acc_store = st; acc_addr = a;
      #5;
      check(req, {31'b0, brk_hit}, {31'b0, exp_hit});
      check(req, {31'b0, brk_idx}, {31'b0, exp_idx});
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", {31'b0, brk_hit}, 0);
      check("R1", {31'b0, mask_fixed}, 0);
      probe("R1", 32'h0, 1'b0, 1'b0, 1'b0);
      probe("R1", 32'h0, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_contig();
      // field 111000: 8-byte region at 0x1000_0040
      wr(0, 0, 32'h1000_0047);
      wr(0, 1, LD | 32'h38);
      check("R6", {31'b0, mask_fixed}, 0);
      probe("R4", 32'h1000_0040, 1'b0, 1'b1, 1'b0);
      probe("R4", 32'h1000_0047, 1'b0, 1'b1, 1'b0);
      probe("R4", 32'h1000_0048, 1'b0, 1'b0, 1'b0);
      probe("R4", 32'h1000_003F, 1'b0, 1'b0, 1'b0);
      probe("R3", 32'h1000_0040, 1'b1, 1'b0, 1'b0);
      probe("R7", 32'h1000_0040, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_noncontig();
      // field 101100 trims to 100000: 32-byte region at 0x2000_0000
      wr(1, 0, 32'h2000_0000);
      wr(1, 1, ST | 32'h2C);
      check("R6", {31'b0, mask_fixed}, 1);
      probe("R5", 32'h2000_0000, 1'b1, 1'b1, 1'b1);
      probe("R5", 32'h2000_001F, 1'b1, 1'b1, 1'b1);
      probe("R5", 32'h2000_001C, 1'b1, 1'b1, 1'b1);
      probe("R5", 32'h2000_0020, 1'b1, 1'b0, 1'b0);
      probe("R3", 32'h2000_0000, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check("R6", {31'b0, mask_fixed}, 1);
   endtask

   task automatic t_flag();
      clr_flag();
      check("R6", {31'b0, mask_fixed}, 0);
      // non-contiguous field with no enables: no flag, watchpoint off
      wr(1, 1, 32'h0000_002C);
      check("R6", {31'b0, mask_fixed}, 0);
      probe("R3", 32'h2000_0000, 1'b1, 1'b0, 1'b0);
      // set and clear in the same cycle: set wins
      @(negedge clk);
      cfg_we = 1'b1; cfg_ctrl = 1'b1; cfg_idx = 1'b1; cfg_wdata = LD | 32'h15;
      mask_fixed_clr = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; mask_fixed_clr = 1'b0;
      check("R6", {31'b0, mask_fixed}, 1);
      clr_flag();
      check("R6", {31'b0, mask_fixed}, 0);
   endtask

   task automatic t_prio();
      wr(0, 0, 32'h3000_0000);
      wr(0, 1, ST | LD | 32'h00);
      wr(1, 0, 32'h3000_0000);
      wr(1, 1, ST | 32'h3F);
      probe("R8", 32'h3000_0000, 1'b1, 1'b1, 1'b0);
      probe("R4", 32'h3000_003F, 1'b1, 1'b1, 1'b0);
      probe("R4", 32'h3000_0040, 1'b1, 1'b0, 1'b0);
      wr(0, 1, 32'h0);
      probe("R9", 32'h3000_0000, 1'b1, 1'b1, 1'b1);
      probe("R4", 32'h3000_0001, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_rearm();
      wr(1, 0, 32'h4000_0100);
      probe("R9", 32'h3000_0000, 1'b1, 1'b0, 1'b0);
      probe("R9", 32'h4000_0100, 1'b1, 1'b1, 1'b1);
      // unused control bits set: behaves like ST | 0x38
      wr(0, 0, 32'h5000_0008);
      wr(0, 1, ST | 32'h3FFF_FFB8);
      check("R2", {31'b0, mask_fixed}, 0);
      probe("R2", 32'h5000_000F, 1'b1, 1'b1, 1'b0);
      probe("R2", 32'h5000_0010, 1'b1, 1'b0, 1'b0);
      probe("R2", 32'h5000_0008, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_contig();
      t_noncontig();
      t_flag();
      t_prio();
      t_rearm();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule